// File: doc/BRIEF.md
# SMM Entry and Exit Gap Monitor

This block is a passive, clocked observer placed on a processor bus. It watches the management-mode active strobe together with the address-strobe and ready-return signals, and measures four clock gaps around each management-mode episode. Two gaps belong to entry: from the last ready of ordinary traffic to the rise of the active strobe, and from that rise to the first address strobe of the state save. Two belong to exit: from the last ready of management-mode traffic to the fall of the active strobe, and from that fall to the first ordinary address strobe.

Each gap is compared with a minimum. The minimum for the gap before the state save depends on a static input that selects a core running at twice or three times the bus clock. A breach raises a one-cycle pulse and a sticky flag for that rule, and the measured count stays on an output port. The block times neither the handler phase nor the length of the save or restore. It reports the nominal save and restore lengths for the selected mode as reference constants.

Top module: `smm_gap_monitor`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `viol_flag`, `viol_pulse` and all four gap outputs read 0.
- R2: Entry-ready gap (rule bit 0). On the clock where `mgmt_act` is first sampled high after being low, the gap is the number of clocks back to the most recent clock where `bus_done` was sampled high. The gap is 0 if that is the same clock. It appears on `gap_a` one clock later. A value below 2 is a violation.
- R3: Save-start gap (rule bit 1). The gap is the number of clocks from the rise of `mgmt_act` to the first later clock where `bus_start` is sampled high. It appears on `gap_b`. A value below 20 is a violation when `core_x3`=0, and a value below 15 is a violation when `core_x3`=1.
- R4: Exit-ready gap (rule bit 2). On the clock where `mgmt_act` is first sampled low after being high, the gap is measured back to the most recent `bus_done`, in the same way as R2. It appears on `gap_f`. A value below 2 is a violation.
- R5: Resume gap (rule bit 3). The gap is the number of clocks from the fall of `mgmt_act` to the first later `bus_start`. It appears on `gap_g`. A value below 20 is a violation.
- R6: A violation sets its `viol_pulse` bit for exactly one clock. The same violation sets its `viol_flag` bit, and that bit stays set until reset.
- R7: Every gap saturates at 255. A gap of 255 clocks or more, or a ready that has never been seen since reset, reads as 255.
- R8: A `bus_start` that arrives with no measurement pending leaves the gap outputs and flags unchanged. This covers the address strobes after the first one in the handler, and those after the first one in normal mode. A fall of `mgmt_act` abandons an unfinished save-start measurement. A rise of `mgmt_act` abandons an unfinished resume measurement.
- R9: `save_ref` reads 139 and `restore_ref` reads 236 when `core_x3`=0. They read 100 and 180 when `core_x3`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_x3 | input | 1 | Static core mode: 0 = doubled core, 1 = tripled core |
| mgmt_act | input | 1 | Management-mode active strobe, active high |
| bus_start | input | 1 | Address strobe, active high |
| bus_done | input | 1 | Ready return, active high |
| viol_flag | output | 4 | Sticky violation flags: bit0 entry-ready, bit1 save-start, bit2 exit-ready, bit3 resume |
| viol_pulse | output | 4 | One-clock violation pulses, same bit order |
| gap_a | output | 8 | Last measured entry-ready gap |
| gap_b | output | 8 | Last measured save-start gap |
| gap_f | output | 8 | Last measured exit-ready gap |
| gap_g | output | 8 | Last measured resume gap |
| save_ref | output | 9 | Nominal state save length for the selected mode |
| restore_ref | output | 9 | Nominal state restore length for the selected mode |

## Verification
A measurement finishes on the clock edge that samples its closing event, which is the `mgmt_act` edge or the first pending `bus_start`. Its count, pulse and flag are registered on that edge and are visible from the following clock. The reference constants follow `core_x3` with no delay. The bench drives inputs on falling edges. Its behavioural model keeps time stamps of the last ready and of each strobe edge and updates on the rising edge, and every output is compared at the next falling edge, one clock after the closing event.

// File: rtl/smm_mon_pkg.sv
package smm_mon_pkg;
   localparam int NRULE = 4;
   typedef enum logic [1:0] {
      RULE_ENTRY_RDY  = 2'd0,
      RULE_SAVE_ADS   = 2'd1,
      RULE_EXIT_RDY   = 2'd2,
      RULE_RESUME_ADS = 2'd3
   } rule_e;
endpackage

// File: rtl/smm_edge_age.sv
module smm_edge_age #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          act,
   input  logic          rdy,
   output logic          act_rise,
   output logic          act_fall,
   output logic [CW-1:0] rdy_gap
);
   localparam logic [CW-1:0] MAXV = '1;

   logic          act_q;
   logic [CW-1:0] age_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         age_q <= MAXV;
      end else begin
         act_q <= act;
         if (rdy)
            age_q <= '0;
         else if (age_q != MAXV)
            age_q <= age_q + 1'b1;
      end
   end

   assign act_rise = act & ~act_q;
   assign act_fall = ~act & act_q;

   always_comb begin
      if (rdy)
         rdy_gap = '0;
      else if (age_q == MAXV)
         rdy_gap = MAXV;
      else
         rdy_gap = age_q + 1'b1;
   end
endmodule

// File: rtl/smm_gap_timer.sv
module smm_gap_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          cancel,
   input  logic          hit,
   output logic          done,
   output logic [CW-1:0] value
);
   localparam logic [CW-1:0] MAXV = '1;

   logic          pend_q;
   logic [CW-1:0] cnt_q;

   assign done  = pend_q & hit;
   assign value = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         cnt_q  <= '0;
      end else if (start) begin
         pend_q <= 1'b1;
         cnt_q  <= CW'(1);
      end else if (done || cancel) begin
         pend_q <= 1'b0;
      end else if (pend_q && cnt_q != MAXV) begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/smm_rule_judge.sv
module smm_rule_judge #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          done,
   input  logic [CW-1:0] value,
   input  logic [CW-1:0] limit,
   output logic          flag,
   output logic          pulse,
   output logic [CW-1:0] gap
);
   logic breach;
   assign breach = done && (value < limit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag  <= 1'b0;
         pulse <= 1'b0;
         gap   <= '0;
      end else begin
         pulse <= breach;
         if (breach) flag <= 1'b1;
         if (done)   gap  <= value;
      end
   end
endmodule

// File: rtl/smm_gap_monitor.sv
module smm_gap_monitor
   import smm_mon_pkg::*;
#(
   parameter int CW       = 8,
   parameter int RW       = 9,
   parameter int MIN_A    = 2,
   parameter int MIN_B_X2 = 20,
   parameter int MIN_B_X3 = 15,
   parameter int MIN_F    = 2,
   parameter int MIN_G    = 20,
   parameter int SAVE_X2  = 139,
   parameter int SAVE_X3  = 100,
   parameter int REST_X2  = 236,
   parameter int REST_X3  = 180
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 core_x3,
   input  logic                 mgmt_act,
   input  logic                 bus_start,
   input  logic                 bus_done,
   output logic [NRULE-1:0]     viol_flag,
   output logic [NRULE-1:0]     viol_pulse,
   output logic [CW-1:0]        gap_a,
   output logic [CW-1:0]        gap_b,
   output logic [CW-1:0]        gap_f,
   output logic [CW-1:0]        gap_g,
   output logic [RW-1:0]        save_ref,
   output logic [RW-1:0]        restore_ref
);
   localparam int CMAX = (1 << CW) - 1;
   localparam int RMAX = (1 << RW) - 1;

   if (CW < 2 || CW > 16) begin : g_bad_cw
      $error("smm_gap_monitor: CW out of range");
   end
   if (MIN_A > CMAX || MIN_B_X2 > CMAX || MIN_B_X3 > CMAX ||
       MIN_F > CMAX || MIN_G > CMAX) begin : g_bad_min
      $error("smm_gap_monitor: a minimum does not fit in CW bits");
   end
   if (SAVE_X2 > RMAX || SAVE_X3 > RMAX ||
       REST_X2 > RMAX || REST_X3 > RMAX) begin : g_bad_ref
      $error("smm_gap_monitor: a reference does not fit in RW bits");
   end

   logic          act_rise, act_fall;
   logic [CW-1:0] rdy_gap;
   logic          b_done, g_done;
   logic [CW-1:0] b_val, g_val;

   smm_edge_age #(.CW(CW)) u_edge (
      .clk(clk), .rst_n(rst_n), .act(mgmt_act), .rdy(bus_done),
      .act_rise(act_rise), .act_fall(act_fall), .rdy_gap(rdy_gap)
   );

   smm_gap_timer #(.CW(CW)) u_save_tmr (
      .clk(clk), .rst_n(rst_n), .start(act_rise), .cancel(act_fall),
      .hit(bus_start), .done(b_done), .value(b_val)
   );

   smm_gap_timer #(.CW(CW)) u_resume_tmr (
      .clk(clk), .rst_n(rst_n), .start(act_fall), .cancel(act_rise),
      .hit(bus_start), .done(g_done), .value(g_val)
   );

   logic          done_v [NRULE];
   logic [CW-1:0] val_v  [NRULE];
   logic [CW-1:0] lim_v  [NRULE];
   logic [CW-1:0] gap_v  [NRULE];

   always_comb begin
      done_v[RULE_ENTRY_RDY]  = act_rise;
      val_v [RULE_ENTRY_RDY]  = rdy_gap;
      lim_v [RULE_ENTRY_RDY]  = CW'(MIN_A);
      done_v[RULE_SAVE_ADS]   = b_done;
      val_v [RULE_SAVE_ADS]   = b_val;
      lim_v [RULE_SAVE_ADS]   = core_x3 ? CW'(MIN_B_X3) : CW'(MIN_B_X2);
      done_v[RULE_EXIT_RDY]   = act_fall;
      val_v [RULE_EXIT_RDY]   = rdy_gap;
      lim_v [RULE_EXIT_RDY]   = CW'(MIN_F);
      done_v[RULE_RESUME_ADS] = g_done;
      val_v [RULE_RESUME_ADS] = g_val;
      lim_v [RULE_RESUME_ADS] = CW'(MIN_G);
   end

   for (genvar gi = 0; gi < NRULE; gi++) begin : g_rule
      smm_rule_judge #(.CW(CW)) u_judge (
         .clk(clk), .rst_n(rst_n), .done(done_v[gi]), .value(val_v[gi]),
         .limit(lim_v[gi]), .flag(viol_flag[gi]), .pulse(viol_pulse[gi]),
         .gap(gap_v[gi])
      );
   end

   assign gap_a = gap_v[RULE_ENTRY_RDY];
   assign gap_b = gap_v[RULE_SAVE_ADS];
   assign gap_f = gap_v[RULE_EXIT_RDY];
   assign gap_g = gap_v[RULE_RESUME_ADS];

   assign save_ref    = core_x3 ? RW'(SAVE_X3) : RW'(SAVE_X2);
   assign restore_ref = core_x3 ? RW'(REST_X3) : RW'(REST_X2);
endmodule

// File: rtl/smm_gap_monitor_chk.sv
module smm_gap_monitor_chk #(
   parameter int CW       = 8,
   parameter int MIN_A    = 2,
   parameter int MIN_B_X2 = 20,
   parameter int MIN_B_X3 = 15,
   parameter int MIN_F    = 2,
   parameter int MIN_G    = 20
) (
   input logic          clk,
   input logic          rst_n,
   input logic          core_x3,
   input logic          mgmt_act,
   input logic [3:0]    viol_flag,
   input logic [3:0]    viol_pulse,
   input logic [CW-1:0] gap_a,
   input logic [CW-1:0] gap_b,
   input logic [CW-1:0] gap_f,
   input logic [CW-1:0] gap_g
);
   AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (viol_flag & $past(viol_flag)) == $past(viol_flag)); // R6
   AST_PULSE_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (viol_pulse & ~viol_flag) == 4'b0000); // R6
   AST_ENTRY_RDY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      viol_pulse[0] |-> (int'(gap_a) < MIN_A) && $past(mgmt_act)); // R2
   AST_SAVE_ADS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      viol_pulse[1] |-> int'(gap_b) < (core_x3 ? MIN_B_X3 : MIN_B_X2)); // R3
   AST_EXIT_RDY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      viol_pulse[2] |-> (int'(gap_f) < MIN_F) && !$past(mgmt_act)); // R4
   AST_RESUME_ADS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      viol_pulse[3] |-> int'(gap_g) < MIN_G); // R5
endmodule

bind smm_gap_monitor smm_gap_monitor_chk #(
   .CW(CW), .MIN_A(MIN_A), .MIN_B_X2(MIN_B_X2), .MIN_B_X3(MIN_B_X3),
   .MIN_F(MIN_F), .MIN_G(MIN_G)
) u_chk (
   .clk(clk), .rst_n(rst_n), .core_x3(core_x3), .mgmt_act(mgmt_act),
   .viol_flag(viol_flag), .viol_pulse(viol_pulse),
   .gap_a(gap_a), .gap_b(gap_b), .gap_f(gap_f), .gap_g(gap_g)
);

// File: tb/tb_smm_gap_monitor.sv
module tb_smm_gap_monitor;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic core_x3 = 1'b0;
   logic mgmt_act = 1'b0;
   logic bus_start = 1'b0;
   logic bus_done = 1'b0;
   logic [3:0] viol_flag, viol_pulse;
   logic [7:0] gap_a, gap_b, gap_f, gap_g;
   logic [8:0] save_ref, restore_ref;

   always #4 clk = ~clk;

   smm_gap_monitor dut (
      .clk(clk), .rst_n(rst_n), .core_x3(core_x3), .mgmt_act(mgmt_act),
      .bus_start(bus_start), .bus_done(bus_done), .viol_flag(viol_flag),
      .viol_pulse(viol_pulse), .gap_a(gap_a), .gap_b(gap_b), .gap_f(gap_f),
      .gap_g(gap_g), .save_ref(save_ref), .restore_ref(restore_ref)
   );

   int errors = 0;
   int checks = 0;
   bit finished = 0;

   // behavioural reference: time stamps, no counters
   int cyc, last_rdy, b_start, g_start;
   bit b_pend, g_pend, prev_act;
   int exp_gap [4];
   bit [3:0] exp_flag, exp_pulse;

   function automatic int sat(input int v);
      return (v > 255) ? 255 : v;
   endfunction

   task automatic judge(input int idx, input int v, input int lim);
      exp_gap[idx] = v;
      if (v < lim) begin
         exp_pulse[idx] = 1'b1;
         exp_flag[idx]  = 1'b1;
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         cyc = 0; last_rdy = -100000; b_pend = 0; g_pend = 0; prev_act = 0;
         for (int i = 0; i < 4; i++) exp_gap[i] = 0;
         exp_flag = '0; exp_pulse = '0;
      end else begin
         cyc++;
         exp_pulse = '0;
         if (bus_done) last_rdy = cyc;
         if (b_pend && bus_start) begin
            judge(1, sat(cyc - b_start), core_x3 ? 15 : 20); b_pend = 0;
         end
         if (g_pend && bus_start) begin
            judge(3, sat(cyc - g_start), 20); g_pend = 0;
         end
         if (mgmt_act && !prev_act) begin
            judge(0, sat(cyc - last_rdy), 2);
            b_pend = 1; b_start = cyc; g_pend = 0;
         end
         if (!mgmt_act && prev_act) begin
            judge(2, sat(cyc - last_rdy), 2);
            g_pend = 1; g_start = cyc; b_pend = 0;
         end
         prev_act = mgmt_act;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at t=%0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk("R2 gap_a", gap_a, exp_gap[0]);
         chk("R3 gap_b", gap_b, exp_gap[1]);
         chk("R4 gap_f", gap_f, exp_gap[2]);
         chk("R5 gap_g", gap_g, exp_gap[3]);
         chk("R6 viol_pulse", viol_pulse, exp_pulse);
         chk("R6 viol_flag", viol_flag, exp_flag);
         chk("R9 save_ref", save_ref, core_x3 ? 100 : 139);
         chk("R9 restore_ref", restore_ref, core_x3 ? 180 : 236);
      end
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask
   task automatic rdy1;
      bus_done = 1; @(negedge clk); bus_done = 0;
   endtask
   task automatic ads1;
      bus_start = 1; @(negedge clk); bus_start = 0;
   endtask
   task automatic do_reset(input bit mode);
      rst_n = 0; core_x3 = mode; mgmt_act = 0; bus_start = 0; bus_done = 0;
      idle(3);
      chk("R1 flag in reset", viol_flag, 0);
      chk("R1 pulse in reset", viol_pulse, 0);
      rst_n = 1;
      @(negedge clk);
      chk("R1 gaps after reset", gap_a + gap_b + gap_f + gap_g, 0);
      chk("R1 flag after reset", viol_flag, 0);
   endtask

   // episode: rdy, ga idle, rise, gb idle, ads, handler, rdy, gf idle, fall, gg idle, ads
   task automatic episode(input int ga, input int gb, input int gf, input int gg);
      rdy1; idle(ga - 1);
      mgmt_act = 1; idle(gb);
      ads1; idle(4); ads1; rdy1; idle(6);
      rdy1; idle(gf - 1);
      mgmt_act = 0; idle(gg);
      ads1; idle(3); ads1; idle(5);
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      #(200000 * 8);
      errors++;
      $display("FAIL watchdog expired");
      finished = 1;
      summary;
      $finish;
   end

   initial begin
      do_reset(0);
      episode(3, 25, 3, 25);                              // legal, doubled
      chk("R6 no flags on legal episode", viol_flag, 0);
      chk("R2 legal entry gap", gap_a, 3);
      episode(1, 10, 1, 5);                               // all four breach
      chk("R6 all flags set", viol_flag, 4'hF);
      episode(4, 30, 4, 30);
      chk("R6 flags held", viol_flag, 4'hF);
      chk("R8 later ads ignored gap_b", gap_b, 30);
      // same-clock rdy and rise gives gap 0
      bus_done = 1; mgmt_act = 1; @(negedge clk); bus_done = 0;
      @(negedge clk);
      chk("R2 zero gap", gap_a, 0);
      mgmt_act = 0; idle(30);                             // fall abandons save timer
      chk("R8 abandoned save gap", gap_b, 30);
      ads1; idle(2);
      do_reset(1);
      episode(3, 16, 3, 21);                              // legal in tripled
      chk("R3 16 legal tripled", viol_flag, 0);
      episode(3, 14, 3, 21);
      chk("R3 14 breach tripled", viol_flag, 4'b0010);
      do_reset(0);
      idle(300);
      mgmt_act = 1; idle(300);
      chk("R7 entry saturate", gap_a, 255);
      ads1; idle(1);
      chk("R7 save saturate", gap_b, 255);
      mgmt_act = 0; idle(20);
      ads1; idle(2);
      finished = 1;
      summary;
      $finish;
   end
endmodule